// File: doc/BRIEF.md
# Eight-Phase Intersection Signal Sequencer

This block runs the lights of a four-way crossing from one repeating cycle of eight equal time units. A free-running prescaler divides the system clock into a one-unit tick. A state machine holding the unit index moves to the next unit on every tick. A decoder turns the unit index into registered lamp outputs:

- Straight traffic on each axis gets a green, a yellow and a red aspect.
- Left turns, right turns and pedestrian crossings get a green aspect only. When they are not green they are dark.

Every road is treated as having equal demand, so every unit has the same fixed length, set by a parameter in clock cycles. The nominal length is about eight seconds.

For hand operation, an operator raises `manual_mode`. The automatic tick is then ignored, and each press of the `step_btn` push-button moves the cycle forward by exactly one unit. The button is synchronized and edge-detected inside the block.

The state machine has eight states, `U0` to `U7`, one per time unit. It has two transitions:
- **advance**: from each state to its successor, with `U7` wrapping to `U0`. It is taken on the tick in automatic mode, or on a detected press in manual mode.
- **hold**: the state stays where it is in every other cycle.

Top module: `xing_phase_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets the unit index to 0, loads the outputs of unit 0 and clears the prescaler. After `rst` is released, unit 0 lasts a full `UNIT_CYCLES` clock cycles.
- R2: In automatic mode the unit index advances by one every `UNIT_CYCLES` clock cycles and wraps from 7 back to 0.
- R3: North-south straight traffic follows this pattern: green in units 0, 1 and 2, yellow in unit 3, and red in units 4 to 7.
- R4: East-west straight traffic follows this pattern: red in units 0 to 3, green in units 4, 5 and 6, and yellow in unit 7.
- R5: Each straight axis shows exactly one of its green, yellow and red aspects. The two axes are never both green or yellow at the same time.
- R6: The north-south walk output is green only in units 2 and 3. The east-west walk output is green only in units 6 and 7.
- R7: The turn outputs are green-only and are off in every other unit:
  - north-south left turn: units 0 and 1
  - north-south right turn: units 0, 1 and 2
  - east-west left turn: units 4 and 5
  - east-west right turn: units 4, 5 and 6
- R8: While `manual_mode` is high, the automatic tick has no effect and the unit index holds.
- R9: In manual mode, each rising edge of `step_btn` advances the unit index by exactly one, however long the button is held. The wrap from 7 to 0 also applies.
- R10: All outputs are registered. `unit_idx` and the lamp outputs change together, one clock cycle after the internal unit state changes, so they always describe the same unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| manual_mode | input | 1 | 1 = step by hand, 0 = automatic time base |
| step_btn | input | 1 | Asynchronous push-button; each rising edge steps one unit in manual mode |
| unit_idx | output | 3 | Current unit index, 0 to 7 |
| ns_green | output | 1 | North-south straight green |
| ns_yellow | output | 1 | North-south straight yellow |
| ns_red | output | 1 | North-south straight red |
| ew_green | output | 1 | East-west straight green |
| ew_yellow | output | 1 | East-west straight yellow |
| ew_red | output | 1 | East-west straight red |
| ns_left | output | 1 | North-south left-turn green |
| ns_right | output | 1 | North-south right-turn green |
| ew_left | output | 1 | East-west left-turn green |
| ew_right | output | 1 | East-west right-turn green |
| ns_walk | output | 1 | North-south pedestrian green |
| ew_walk | output | 1 | East-west pedestrian green |

## Verification
The assertions assume three things about the inputs:
- `UNIT_CYCLES` is at least 2, so a tick never lasts two cycles in a row.
- `step_btn` is a slow human input, and the state machine only ever sees its synchronized single-cycle pulse.
- `manual_mode` is quasi-static and changes only between operator actions.

The stimulus follows these assumptions. The bench uses a short unit length, and changes `manual_mode` only well away from a tick boundary. It holds each button press for several cycles, then waits longer than the synchronizer and output latency before the next press.

// File: rtl/xing_pkg.sv
package xing_pkg;

    typedef enum logic [2:0] {
        U0 = 3'd0, U1 = 3'd1, U2 = 3'd2, U3 = 3'd3,
        U4 = 3'd4, U5 = 3'd5, U6 = 3'd6, U7 = 3'd7
    } unit_e;

    typedef struct packed {
        logic ns_g;
        logic ns_y;
        logic ns_r;
        logic ew_g;
        logic ew_y;
        logic ew_r;
        logic ns_lt;
        logic ns_rt;
        logic ew_lt;
        logic ew_rt;
        logic ns_walk;
        logic ew_walk;
    } lamp_t;

    function automatic lamp_t lamp_decode(input unit_e u);
        lamp_t l;
        l = '0;
        unique case (u)
            U0, U1: begin
                l.ns_g = 1'b1; l.ew_r = 1'b1;
                l.ns_lt = 1'b1; l.ns_rt = 1'b1;
            end
            U2: begin
                l.ns_g = 1'b1; l.ew_r = 1'b1;
                l.ns_rt = 1'b1; l.ns_walk = 1'b1;
            end
            U3: begin
                l.ns_y = 1'b1; l.ew_r = 1'b1;
                l.ns_walk = 1'b1;
            end
            U4, U5: begin
                l.ns_r = 1'b1; l.ew_g = 1'b1;
                l.ew_lt = 1'b1; l.ew_rt = 1'b1;
            end
            U6: begin
                l.ns_r = 1'b1; l.ew_g = 1'b1;
                l.ew_rt = 1'b1; l.ew_walk = 1'b1;
            end
            U7: begin
                l.ns_r = 1'b1; l.ew_y = 1'b1;
                l.ew_walk = 1'b1;
            end
            default: l = '0;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/xing_tick_gen.sv
module xing_tick_gen #(
    parameter int unsigned UNIT_CYCLES = 400_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned CW = (UNIT_CYCLES > 2) ? $clog2(UNIT_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(UNIT_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = (cnt_q == LAST);

    // R2: the count never leaves its window
    a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    // R2: a tick is a single-cycle pulse
    a_r2_tick_single: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    // R1: the prescaler restarts from zero after reset
    a_r1_cnt_cleared: assert property (@(posedge clk)
        rst |=> (cnt_q == '0));

endmodule

// File: rtl/xing_step_sync.sv
module xing_step_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic btn_async,
    output logic step_pulse
);
    logic [SYNC_STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[SYNC_STAGES-1:0], btn_async};
        end
    end

    assign step_pulse = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];

    // R9: a held button yields one pulse only
    a_r9_pulse_single: assert property (@(posedge clk) disable iff (rst)
        step_pulse |=> !step_pulse);

endmodule

// File: rtl/xing_unit_fsm.sv
module xing_unit_fsm
    import xing_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  manual_i,
    input  logic  tick_i,
    input  logic  step_i,
    output unit_e unit_o
);
    unit_e state_q, state_d;
    logic  adv;

    assign adv = manual_i ? step_i : tick_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= U0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (adv) begin
            unique case (state_q)
                U0: state_d = U1;
                U1: state_d = U2;
                U2: state_d = U3;
                U3: state_d = U4;
                U4: state_d = U5;
                U5: state_d = U6;
                U6: state_d = U7;
                U7: state_d = U0;
                default: state_d = U0;
            endcase
        end
    end

    assign unit_o = state_q;

    // R8: in manual mode, without a press, the unit holds
    a_r8_manual_hold: assert property (@(posedge clk) disable iff (rst)
        (manual_i && !step_i) |=> $stable(state_q));

    // R2: in automatic mode the unit moves only on a tick
    a_r2_auto_hold: assert property (@(posedge clk) disable iff (rst)
        (!manual_i && !tick_i) |=> $stable(state_q));

    // R9: every advance moves forward by exactly one, modulo eight
    a_r9_step_by_one: assert property (@(posedge clk) disable iff (rst)
        (manual_i && step_i) |=> (3'(state_q) == 3'(3'($past(state_q)) + 3'd1)));

    // R1: reset lands in unit 0
    a_r1_reset_u0: assert property (@(posedge clk)
        rst |=> (state_q == U0));

endmodule

// File: rtl/xing_lamp_reg.sv
module xing_lamp_reg
    import xing_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  unit_e      unit_i,
    output lamp_t      lamp_o,
    output logic [2:0] idx_o
);
    lamp_t      lamp_q;
    logic [2:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lamp_q <= lamp_decode(U0);
            idx_q  <= 3'd0;
        end else begin
            lamp_q <= lamp_decode(unit_i);
            idx_q  <= 3'(unit_i);
        end
    end

    assign lamp_o = lamp_q;
    assign idx_o  = idx_q;

    // R5: each straight axis shows exactly one aspect
    a_r5_ns_one_aspect: assert property (@(posedge clk) disable iff (rst)
        $onehot({lamp_q.ns_g, lamp_q.ns_y, lamp_q.ns_r}));
    a_r5_ew_one_aspect: assert property (@(posedge clk) disable iff (rst)
        $onehot({lamp_q.ew_g, lamp_q.ew_y, lamp_q.ew_r}));

    // R5: the two straight axes never run together
    a_r5_no_conflict: assert property (@(posedge clk) disable iff (rst)
        !((lamp_q.ns_g || lamp_q.ns_y) && (lamp_q.ew_g || lamp_q.ew_y)));

    // R6: each walk runs only while cross traffic is red, never both walks
    a_r6_ns_walk_safe: assert property (@(posedge clk) disable iff (rst)
        lamp_q.ns_walk |-> lamp_q.ew_r);
    a_r6_ew_walk_safe: assert property (@(posedge clk) disable iff (rst)
        lamp_q.ew_walk |-> lamp_q.ns_r);
    a_r6_walk_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({lamp_q.ns_walk, lamp_q.ew_walk}));

    // R10: the index output tracks the unit state one cycle later
    a_r10_idx_follows: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (idx_q == 3'($past(unit_i))));

endmodule

// File: rtl/xing_phase_ctrl.sv
module xing_phase_ctrl
    import xing_pkg::*;
#(
    parameter int unsigned UNIT_CYCLES = 400_000_000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       manual_mode,
    input  logic       step_btn,
    output logic [2:0] unit_idx,
    output logic       ns_green,
    output logic       ns_yellow,
    output logic       ns_red,
    output logic       ew_green,
    output logic       ew_yellow,
    output logic       ew_red,
    output logic       ns_left,
    output logic       ns_right,
    output logic       ew_left,
    output logic       ew_right,
    output logic       ns_walk,
    output logic       ew_walk
);
    logic  tick;
    logic  step_pulse;
    unit_e unit;
    lamp_t lamp;

    xing_tick_gen #(.UNIT_CYCLES(UNIT_CYCLES)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    xing_step_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .btn_async  (step_btn),
        .step_pulse (step_pulse)
    );

    xing_unit_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .manual_i (manual_mode),
        .tick_i   (tick),
        .step_i   (step_pulse),
        .unit_o   (unit)
    );

    xing_lamp_reg u_lamp (
        .clk    (clk),
        .rst    (rst),
        .unit_i (unit),
        .lamp_o (lamp),
        .idx_o  (unit_idx)
    );

    assign ns_green  = lamp.ns_g;
    assign ns_yellow = lamp.ns_y;
    assign ns_red    = lamp.ns_r;
    assign ew_green  = lamp.ew_g;
    assign ew_yellow = lamp.ew_y;
    assign ew_red    = lamp.ew_r;
    assign ns_left   = lamp.ns_lt;
    assign ns_right  = lamp.ns_rt;
    assign ew_left   = lamp.ew_lt;
    assign ew_right  = lamp.ew_rt;
    assign ns_walk   = lamp.ns_walk;
    assign ew_walk   = lamp.ew_walk;

endmodule

// File: tb/xing_phase_ctrl_bench.sv
`timescale 1ns/1ps
module xing_phase_ctrl_bench;

    localparam int UNIT = 10;

    // lamp word: {nsG,nsY,nsR, ewG,ewY,ewR, nsL,nsRt,ewL,ewRt, nsWalk,ewWalk}
    localparam logic [11:0] VEC [8] = '{
        12'b100_001_1100_00,
        12'b100_001_1100_00,
        12'b100_001_0100_10,
        12'b010_001_0000_10,
        12'b001_100_0011_00,
        12'b001_100_0011_00,
        12'b001_100_0001_01,
        12'b001_010_0000_01
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic manual_mode = 1'b0;
    logic step_btn = 1'b0;
    logic [2:0] unit_idx;
    logic ns_green, ns_yellow, ns_red, ew_green, ew_yellow, ew_red;
    logic ns_left, ns_right, ew_left, ew_right, ns_walk, ew_walk;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    xing_phase_ctrl #(.UNIT_CYCLES(UNIT)) u_xing_phase_ctrl (
        .clk(clk), .rst(rst), .manual_mode(manual_mode), .step_btn(step_btn),
        .unit_idx(unit_idx),
        .ns_green(ns_green), .ns_yellow(ns_yellow), .ns_red(ns_red),
        .ew_green(ew_green), .ew_yellow(ew_yellow), .ew_red(ew_red),
        .ns_left(ns_left), .ns_right(ns_right), .ew_left(ew_left),
        .ew_right(ew_right), .ns_walk(ns_walk), .ew_walk(ew_walk)
    );

    function automatic logic [11:0] lamps();
        return {ns_green, ns_yellow, ns_red, ew_green, ew_yellow, ew_red,
                ns_left, ns_right, ew_left, ew_right, ns_walk, ew_walk};
    endfunction

    task automatic check_unit(input logic [2:0] exp_idx, input string tag);
        n_vec++;
        if (unit_idx !== exp_idx || lamps() !== VEC[exp_idx]) begin
            n_bad++;
            $display("FAIL %s: idx=%0d lamps=%b expected idx=%0d lamps=%b",
                     tag, unit_idx, lamps(), exp_idx, VEC[exp_idx]);
        end
        // R5: straight axes never both moving
        n_vec++;
        if ((ns_green | ns_yellow) & (ew_green | ew_yellow)) begin
            n_bad++;
            $display("FAIL R5: conflict ns=%b%b ew=%b%b expected no overlap",
                     ns_green, ns_yellow, ew_green, ew_yellow);
        end
    endtask

    task automatic press();
        @(negedge clk) step_btn = 1'b1;
        repeat (5) @(negedge clk);
        step_btn = 1'b0;
        repeat (8) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            finish_run();
        end
    end

    initial begin
        logic [2:0] exp;
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check_unit(3'd0, "R1 reset");
        @(negedge clk) rst = 1'b0;

        // R2/R3/R4/R6/R7/R10: automatic walk over two full cycles
        repeat (5) @(posedge clk);
        #1;
        for (int k = 0; k < 16; k++) begin
            if (k != 0) begin
                repeat (UNIT) @(posedge clk);
                #1;
            end
            check_unit(3'(k), "R2 R3 R4 R6 R7 R10 auto");
        end
        // counter is in unit 7 here; switch to manual before the next tick
        manual_mode = 1'b1;

        // R8: tick ignored in manual mode
        repeat (5 * UNIT) @(posedge clk);
        #1;
        check_unit(3'd7, "R8 manual hold");

        // R9: one unit per press, wrap included
        exp = 3'd7;
        for (int p = 0; p < 9; p++) begin
            press();
            exp = exp + 3'd1;
            check_unit(exp, "R9 manual step");
        end
        // R8: still holding after presses stop
        repeat (3 * UNIT) @(posedge clk);
        #1;
        check_unit(exp, "R8 hold after steps");

        // R1: reset mid-run, then full-length first unit
        @(negedge clk) rst = 1'b1;
        manual_mode = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check_unit(3'd0, "R1 reset mid-run");
        @(negedge clk) rst = 1'b0;
        repeat (UNIT) @(posedge clk);
        #1;
        check_unit(3'd0, "R1 first unit full length");
        @(posedge clk);
        #1;
        check_unit(3'd1, "R1 R10 first advance");

        done = 1'b1;
        finish_run();
    end

endmodule